// File: doc/BRIEF.md
# Supervisory Reset Hold Generator

This block merges the reasons a processor must be held in reset into one reset line. Three causes feed it. An undervoltage flag comes from an external comparator. An active-low manual reset pin is synchronised and filtered against glitches. A one-cycle watchdog expiry pulse comes from a separate watchdog timer. Once every cause has cleared, the line stays asserted for a fixed number of 1 ms tick enables and then releases.

Six hold lengths exist, each 1.5 times a minimum of 10, 40, 150, 1200, 300 or 600 ms. The parameter `TIMEOUT_OPT` picks one of them with codes 1 to 6, in that order. When `SEL_EN` is set, the `sel_i` pin chooses between code 1 and code 3 instead. The pin is only sampled while reset is deasserted, so a period in progress always finishes at the length it started with. `ACTIVE_HIGH` sets the polarity of `rst_o`.

Top module: `reset_hold_gen`

## Requirements
- R1: While `uv_i` is 1, reset is asserted in the same cycle, before any clock edge.
- R2: The manual reset pin passes through a 2-stage synchroniser and a filter. Reset asserts only after `MR_FILT_LEN` (default 4) consecutive low samples, which shows on the output 6 clock edges after `mr_ni` falls. Shorter low pulses leave the output deasserted.
- R3: Once the last level cause (`uv_i`, or the filtered manual reset) clears, reset stays asserted until exactly P ticks have been counted, and then deasserts.
- R4: A one-cycle `wd_i` pulse asserts reset in that cycle and starts a full hold of P ticks. No release is needed.
- R5: A cause that reappears during the hold reloads the counter. A full P ticks then runs once the cause clears again.
- R6: With `SEL_EN`=0, P in ticks is 15, 60, 225, 1800, 450 or 900 for `TIMEOUT_OPT` 1, 2, 3, 4, 5 or 6.
- R7: With `SEL_EN`=1, `sel_i`=0 gives P=15 and `sel_i`=1 gives P=225.
- R8: `sel_i` is sampled only on edges where reset was deasserted. A change made while reset is asserted leaves the current period unchanged and applies to the next one.
- R9: When `ACTIVE_HIGH`=0, `rst_o` is 0 while asserted and 1 otherwise. When `ACTIVE_HIGH`=1, it is exactly the inverse.
- R10: After `rst_ni` is released, reset is asserted and runs a full hold. P is taken from `sel_i`=0 when `SEL_EN`=1.
- R11: The hold counts only edges on which `tick_i` is 1. Cycles without a tick do not advance it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low system reset |
| tick_i | input | 1 | One-cycle 1 ms tick enable |
| uv_i | input | 1 | Undervoltage flag, active high, synchronous |
| mr_ni | input | 1 | Manual reset pin, active low, asynchronous |
| wd_i | input | 1 | Watchdog expiry pulse, one cycle |
| sel_i | input | 1 | Runtime period select (SEL_EN=1 only) |
| rst_o | output | 1 | Reset output, polarity set by ACTIVE_HIGH |

## Verification
The hardest situation to reach from the ports is a `sel_i` change that lands inside a running hold. The bench raises a cause, lets a few ticks pass, flips the select, and then counts ticks until release. It expects the old length for that period and the new length for the next one. A sweep of manual reset pulse widths around the filter length checks both the accept boundary and the exact assertion latency. A bank of six fixed-option instances, with alternating polarity, is timed from reset release to confirm every period code.

// File: rtl/rhg_pkg.sv
package rhg_pkg;
  localparam int unsigned NUM_OPTS = 6;

  function automatic int unsigned opt_min_ms(input int unsigned code);
    case (code)
      1:       return 10;
      2:       return 40;
      3:       return 150;
      4:       return 1200;
      5:       return 300;
      6:       return 600;
      default: return 10;
    endcase
  endfunction

  // typical hold = 1.5 x minimum, in ticks
  function automatic int unsigned opt_ticks(input int unsigned code);
    return (opt_min_ms(code) * 3) / 2;
  endfunction
endpackage

// File: rtl/rhg_mr_filter.sv
module rhg_mr_filter #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned FILT_LEN    = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mr_ni,
  output logic mr_act_o
);
  localparam int unsigned CW = $clog2(FILT_LEN + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0]          lo_cnt_q;
  logic                   act_q;
  logic                   mr_lo;

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q[0] <= 1'b1;
        else         sync_q[0] <= mr_ni;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q[s] <= 1'b1;
        else         sync_q[s] <= sync_q[s-1];
      end
    end
  end

  assign mr_lo = ~sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_cnt_q <= '0;
      act_q    <= 1'b0;
    end else if (!mr_lo) begin
      lo_cnt_q <= '0;
      act_q    <= 1'b0;
    end else if (lo_cnt_q == CW'(FILT_LEN - 1)) begin
      act_q    <= 1'b1;
    end else if (!act_q) begin
      lo_cnt_q <= lo_cnt_q + CW'(1);
    end
  end

  assign mr_act_o = act_q;
endmodule

// File: rtl/rhg_period_sel.sv
module rhg_period_sel #(
  parameter bit          SEL_EN      = 1'b1,
  parameter int unsigned TIMEOUT_OPT = 1,
  parameter int unsigned CNT_W       = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sel_i,
  input  logic             hold_i,
  output logic [CNT_W-1:0] period_o
);
  localparam logic [CNT_W-1:0] LO_P  = CNT_W'(rhg_pkg::opt_ticks(1));
  localparam logic [CNT_W-1:0] HI_P  = CNT_W'(rhg_pkg::opt_ticks(3));
  localparam logic [CNT_W-1:0] FIX_P = CNT_W'(rhg_pkg::opt_ticks(TIMEOUT_OPT));

  if (SEL_EN) begin : g_pin
    logic [CNT_W-1:0] period_q;
    // frozen while reset is asserted
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      period_q <= LO_P;
      else if (!hold_i) period_q <= sel_i ? HI_P : LO_P;
    end
    assign period_o = period_q;
  end else begin : g_fixed
    logic unused_pins;
    assign unused_pins = ^{clk_i, rst_ni, sel_i, hold_i};
    assign period_o = FIX_P;
  end
endmodule

// File: rtl/rhg_hold_ctr.sv
module rhg_hold_ctr #(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             cause_i,
  input  logic [CNT_W-1:0] period_i,
  output logic             active_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic             active_q;
  logic [CNT_W-1:0] cnt_q;
  logic             last_tick;

  assign last_tick = (cnt_q == period_i - CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
    end else if (cause_i) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
    end else if (active_q && tick_i) begin
      if (last_tick) begin
        active_q <= 1'b0;
        cnt_q    <= '0;
      end else begin
        cnt_q    <= cnt_q + CNT_W'(1);
      end
    end
  end

  assign active_o = active_q;
  assign cnt_o    = cnt_q;
endmodule

// File: rtl/reset_hold_gen.sv
module reset_hold_gen #(
  parameter int unsigned TIMEOUT_OPT = 1,
  parameter bit          SEL_EN      = 1'b1,
  parameter bit          ACTIVE_HIGH = 1'b0,
  parameter int unsigned MR_SYNC     = 2,
  parameter int unsigned MR_FILT_LEN = 4,
  parameter int unsigned MAX_HOLD_MS = 2400
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic uv_i,
  input  logic mr_ni,
  input  logic wd_i,
  input  logic sel_i,
  output logic rst_o
);
  localparam int unsigned CNT_W = $clog2(MAX_HOLD_MS + 1);

  logic             mr_act;
  logic             trig;
  logic             rst_asserted;
  logic             hold_active;
  logic [CNT_W-1:0] hold_cnt;
  logic [CNT_W-1:0] period;

  rhg_mr_filter #(
    .SYNC_STAGES(MR_SYNC),
    .FILT_LEN   (MR_FILT_LEN)
  ) u_mr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .mr_ni   (mr_ni),
    .mr_act_o(mr_act)
  );

  assign trig         = uv_i | mr_act | wd_i;
  assign rst_asserted = hold_active | trig;

  rhg_period_sel #(
    .SEL_EN     (SEL_EN),
    .TIMEOUT_OPT(TIMEOUT_OPT),
    .CNT_W      (CNT_W)
  ) u_sel (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sel_i   (sel_i),
    .hold_i  (rst_asserted),
    .period_o(period)
  );

  rhg_hold_ctr #(
    .CNT_W(CNT_W)
  ) u_hold (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick_i),
    .cause_i (trig),
    .period_i(period),
    .active_o(hold_active),
    .cnt_o   (hold_cnt)
  );

  if (ACTIVE_HIGH) begin : g_hi
    assign rst_o = rst_asserted;
  end else begin : g_lo
    assign rst_o = ~rst_asserted;
  end
endmodule

// File: rtl/rhg_checker.sv
module rhg_checker #(
  parameter bit          ACTIVE_HIGH = 1'b0,
  parameter int unsigned CNT_W       = 12
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic             uv_i,
  input logic             wd_i,
  input logic             rst_o,
  input logic             hold_active,
  input logic [CNT_W-1:0] hold_cnt,
  input logic [CNT_W-1:0] period
);
  logic asrt;
  assign asrt = ACTIVE_HIGH ? rst_o : ~rst_o;

  AST_UV_IMMEDIATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uv_i |-> asrt); // R1
  AST_WD_IMMEDIATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wd_i |-> asrt); // R4
  AST_WD_STARTS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wd_i |=> (hold_active && hold_cnt == '0)); // R4
  AST_CNT_BELOW_PERIOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_active |-> (hold_cnt < period)); // R3
  AST_RELEASE_AT_PERIOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hold_active) |-> ($past(hold_cnt) == $past(period) - CNT_W'(1))); // R3
  AST_RELEASE_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hold_active) |-> ($past(tick_i) && !$past(uv_i) && !$past(wd_i))); // R11
  AST_PERIOD_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(asrt) |-> $stable(period)); // R8
endmodule

bind reset_hold_gen rhg_checker #(
  .ACTIVE_HIGH(ACTIVE_HIGH),
  .CNT_W      (CNT_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tick_i     (tick_i),
  .uv_i       (uv_i),
  .wd_i       (wd_i),
  .rst_o      (rst_o),
  .hold_active(hold_active),
  .hold_cnt   (hold_cnt),
  .period     (period)
);

// File: tb/reset_hold_gen_tb_top.sv
module reset_hold_gen_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic uv = 1'b0;
  logic mr_n = 1'b1;
  logic wd = 1'b0;
  logic sel = 1'b0;
  logic rst_out;
  logic [5:0] opt_rst;

  int tests = 0;
  int fails = 0;
  int cycles = 0;
  int tdiv = 1;
  int div_cnt = 0;
  bit tick_seen = 1'b0;

  localparam int FILT = 4;

  always #10 clk = ~clk;

  reset_hold_gen #(.SEL_EN(1'b1), .ACTIVE_HIGH(1'b0), .MR_FILT_LEN(FILT)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .uv_i(uv), .mr_ni(mr_n),
    .wd_i(wd), .sel_i(sel), .rst_o(rst_out)
  );

  for (genvar g = 0; g < 6; g++) begin : g_opt
    reset_hold_gen #(.TIMEOUT_OPT(g + 1), .SEL_EN(1'b0), .ACTIVE_HIGH(g % 2 == 1)) opt_i (
      .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .uv_i(uv), .mr_ni(mr_n),
      .wd_i(wd), .sel_i(sel), .rst_o(opt_rst[g])
    );
  end

  function automatic int exp_ticks(input int code);
    int mins [6] = '{10, 40, 150, 1200, 300, 600};
    return mins[code-1] * 3 / 2;
  endfunction

  function automatic bit opt_asrt(input int g);
    return (g % 2 == 1) ? opt_rst[g] : ~opt_rst[g];
  endfunction

  function automatic bit dut_asrt();
    return ~rst_out;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  // called at a negedge; drives tick, clocks once, returns at next negedge
  task automatic step();
    tick = (div_cnt == 0);
    div_cnt = (div_cnt + 1) % tdiv;
    tick_seen = tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic hold_check(input int p, input string tag, output int cyc);
    int  n = 0;
    bit  held = 1'b1;
    cyc = 0;
    while (n < p && cyc < 5000) begin
      if (!dut_asrt()) held = 1'b0;
      step();
      cyc++;
      if (tick_seen) n++;
    end
    chk(held, tag, 0, 1);
    chk(!dut_asrt(), tag, int'(dut_asrt()), 0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 100000);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int cyc;
    int first [7];
    bool_loop: begin end
    repeat (3) @(negedge clk);
    chk(rst_out == 1'b0, "R10", int'(rst_out), 0);
    for (int g = 0; g < 6; g++)
      chk(opt_rst[g] == ((g % 2 == 1) ? 1'b1 : 1'b0), "R9", int'(opt_rst[g]), g % 2);
    rst_n = 1'b1;

    // R6 R10: time each instance from reset release
    for (int i = 0; i < 7; i++) first[i] = -1;
    begin
      int t = 0;
      for (int k = 0; k < 2000; k++) begin
        step();
        if (tick_seen) t++;
        if (first[6] < 0 && !dut_asrt()) first[6] = t;
        for (int g = 0; g < 6; g++)
          if (first[g] < 0 && !opt_asrt(g)) first[g] = t;
      end
    end
    chk(first[6] == 15, "R10", first[6], 15);
    for (int g = 0; g < 6; g++)
      chk(first[g] == exp_ticks(g + 1), "R6", first[g], exp_ticks(g + 1));
    for (int g = 0; g < 6; g++)
      chk(opt_rst[g] == ((g % 2 == 1) ? 1'b0 : 1'b1), "R9", int'(opt_rst[g]), 1 - g % 2);

    // R1 R3: undervoltage level
    uv = 1'b1;
    #1 chk(dut_asrt(), "R1", int'(dut_asrt()), 1);
    repeat (5) step();
    uv = 1'b0;
    hold_check(15, "R3", cyc);

    // R11: sparse ticks
    tdiv = 3; div_cnt = 0;
    uv = 1'b1; step(); uv = 1'b0;
    hold_check(15, "R11", cyc);
    chk(cyc >= 43 && cyc <= 45, "R11", cyc, 44);
    tdiv = 1; div_cnt = 0;
    repeat (2) step();

    // R5: cause returns mid-hold
    uv = 1'b1; step(); uv = 1'b0;
    repeat (8) step();
    chk(dut_asrt(), "R5", int'(dut_asrt()), 1);
    uv = 1'b1; step(); uv = 1'b0;
    hold_check(15, "R5", cyc);
    repeat (2) step();

    // R4: watchdog pulse
    wd = 1'b1;
    #1 chk(dut_asrt(), "R4", int'(dut_asrt()), 1);
    step();
    wd = 1'b0;
    hold_check(15, "R4", cyc);
    repeat (2) step();

    // R2: manual reset pulse width sweep
    for (int w = 1; w <= FILT + 2; w++) begin
      int fa = -1;
      mr_n = 1'b0;
      for (int k = 1; k <= w + 3; k++) begin
        if (k == w + 1) mr_n = 1'b1;
        step();
        if (fa < 0 && dut_asrt()) fa = k;
      end
      if (w >= FILT) begin
        chk(fa == FILT + 2, "R2", fa, FILT + 2);
        hold_check(15, "R2", cyc);
      end else begin
        repeat (3) begin
          step();
          if (fa < 0 && dut_asrt()) fa = 99;
        end
        chk(fa < 0, "R2", fa, -1);
      end
      repeat (2) step();
    end

    // R7 R8: runtime select
    sel = 1'b1; repeat (2) step();
    uv = 1'b1; step(); uv = 1'b0;
    hold_check(225, "R7", cyc);
    sel = 1'b0; repeat (2) step();
    uv = 1'b1; step(); uv = 1'b0;
    hold_check(15, "R7", cyc);
    repeat (2) step();
    uv = 1'b1; step(); uv = 1'b0;
    repeat (3) step();
    sel = 1'b1;
    hold_check(12, "R8", cyc);
    repeat (2) step();
    uv = 1'b1; step(); uv = 1'b0;
    hold_check(225, "R8", cyc);
    sel = 1'b0;
    repeat (2) step();

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule